// File: doc/BRIEF.md
# Sequential Fault Injection Scheduler

This block drives a wide bus of fault-enable lines, one line for each fault site in a design under test. The fault sites are wired to those lines. After a start pulse it works through a fixed list of faults in order, beginning with fault 0. It raises each fault's line for a fixed number of clock cycles. It then holds the line low for the rest of that fault's slot, so the effect of the fault can spread and be captured before the next fault begins.

Each fault has two compile-time counts, both packed into parameter vectors with fault 0 in the least significant field. The first count is its active duration. The second is its total slot length. A separate parameter states how many entries of the list are in use. An index output always shows which fault is scheduled. A done flag rises when the last used slot has expired.

Top module: `fault_slot_sequencer`

## Requirements
- R1: When `rst` is sampled high at a clock edge, the block becomes idle after that edge: `fault_en` is all zero, `fault_idx` is 0, and `busy` and `done` are 0.
- R2: When `start` is sampled high while the block is idle, the edge starts fault 0. From that edge on, `busy` is 1, `fault_idx` is 0 and `fault_en` bit 0 is 1, provided fault 0 has a non-zero active count.
- R3: During the slot of fault i, bit i of `fault_en` is high for exactly ACT_CYC field i cycles, counted from the first cycle of the slot. Every other bit stays low, so at most one bit is high at any time.
- R4: The slot of fault i lasts exactly its effective length in cycles. The next fault's slot begins in the cycle right after. For the cycles after the active window, `fault_en` is all zero.
- R5: The effective slot length is the largest of SLOT_CYC field i, ACT_CYC field i and 1. A slot count shorter than the active count therefore stretches to the active count, and a fault whose counts are both zero still takes one cycle.
- R6: `fault_idx` gives the number of the fault whose slot is running, and it never reaches USED.
- R7: After the slot of fault USED-1 ends, `done` is 1 and `busy` is 0, and `fault_en` stays all zero until the next start. Bits USED and above are never driven high.
- R8: A `start` pulse while `busy` is 1 has no effect on the schedule.
- R9: A `start` pulse while `done` is 1 clears `done` and runs the whole list again from fault 0.
- R10: `rst` sampled high in the middle of a run stops the run at once, with the outputs as given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins the list at fault 0 when the block is not busy |
| fault_en | output | BUS_W | One enable line per fault, active high |
| fault_idx | output | IW | Index of the fault whose slot is running |
| busy | output | 1 | High while a schedule is in progress |
| done | output | 1 | High after the last used slot has ended, until the next start or reset |

## Verification
The bench runs a four-fault list chosen so that each kind of slot appears once. One fault has a plain active window followed by a gap. One has an active count of zero and a short gap, so its line never rises. One has a slot count below its active count, which tests the stretching rule. The last ends in a gap. A model in the bench is compared with the design on every cycle, and a per-fault tally of high cycles and slot cycles is checked when each run finishes, so an error in the pulse width can be told apart from an error in slot timing. Further runs add a start pulse in the middle of a run, a restart after done, and a reset in the middle of a slot. These show whether the ignore, restart and abort paths change the schedule in the way R8 to R10 say.

// File: rtl/fault_slot_sequencer.sv
module fault_slot_sequencer #(
  parameter int MAX_FAULTS = 63,
  parameter int BUS_W      = MAX_FAULTS + 1,
  parameter int USED       = 4,
  parameter int CW         = 8,
  parameter logic [MAX_FAULTS*CW-1:0] ACT_CYC  = {MAX_FAULTS{CW'(3)}},
  parameter logic [MAX_FAULTS*CW-1:0] SLOT_CYC = {MAX_FAULTS{CW'(8)}},
  localparam int IW = $clog2(BUS_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic [BUS_W-1:0] fault_en,
  output logic [IW-1:0]    fault_idx,
  output logic             busy,
  output logic             done
);

  logic [CW-1:0] cnt;
  logic [CW-1:0] act_c, slot_c, eff_c;
  logic          slot_end, last_fault;

  assign act_c      = ACT_CYC[fault_idx*CW +: CW];
  assign slot_c     = SLOT_CYC[fault_idx*CW +: CW];
  assign eff_c      = (slot_c > act_c) ? slot_c : act_c;
  assign slot_end   = (eff_c == '0) || (cnt == eff_c - 1'b1);
  assign last_fault = (fault_idx == IW'(USED - 1));

  always_comb begin
    fault_en = '0;
    if (busy && (cnt < act_c))
      fault_en[fault_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      cnt       <= '0;
      fault_idx <= '0;
    end else if (!busy) begin
      if (start) begin
        busy      <= 1'b1;
        done      <= 1'b0;
        cnt       <= '0;
        fault_idx <= '0;
      end
    end else if (slot_end) begin
      cnt <= '0;
      if (last_fault) begin
        busy      <= 1'b0;
        done      <= 1'b1;
        fault_idx <= '0;
      end else begin
        fault_idx <= fault_idx + 1'b1;
      end
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

endmodule

module fault_slot_sequencer_chk #(
  parameter int BUS_W = 64,
  parameter int USED  = 4,
  parameter int IW    = 6
) (
  input logic             clk,
  input logic             rst,
  input logic             start,
  input logic [BUS_W-1:0] fault_en,
  input logic [IW-1:0]    fault_idx,
  input logic             busy,
  input logic             done
);

  assert_onehot_en_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(fault_en));

  assert_en_only_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (fault_en != '0) |-> busy);

  assert_done_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (fault_en == '0) && !busy);

  assert_idx_range_R6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (fault_idx < IW'(USED)));

  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !done) |=> (done || (fault_idx >= $past(fault_idx))));

  assert_reset_state_R10: assert property (@(posedge clk)
    rst |=> (fault_en == '0) && (fault_idx == '0) && !busy && !done);

endmodule

bind fault_slot_sequencer fault_slot_sequencer_chk #(
  .BUS_W(BUS_W), .USED(USED), .IW(IW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .fault_en(fault_en),
  .fault_idx(fault_idx), .busy(busy), .done(done)
);

// File: tb/tb_fault_slot_sequencer.sv
module tb_fault_slot_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int MAXF = 63;
  localparam int BW   = 64;
  localparam int U    = 4;
  localparam int CW   = 8;
  localparam int IWB  = 6;
  localparam logic [MAXF*CW-1:0] ACT  = {{59{8'd1}}, 8'd2, 8'd5, 8'd0, 8'd3};
  localparam logic [MAXF*CW-1:0] SLOT = {{59{8'd1}}, 8'd4, 8'd3, 8'd2, 8'd6};

  logic clk = 0, rst = 1, start = 0;
  logic [BW-1:0]  fault_en;
  logic [IWB-1:0] fault_idx;
  logic busy, done;
  int checks = 0, errors = 0, cyc = 0;

  fault_slot_sequencer #(.MAX_FAULTS(MAXF), .BUS_W(BW), .USED(U), .CW(CW),
    .ACT_CYC(ACT), .SLOT_CYC(SLOT)) dut (
    .clk(clk), .rst(rst), .start(start), .fault_en(fault_en),
    .fault_idx(fault_idx), .busy(busy), .done(done));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int act_of(int i);
    return int'(ACT[i*CW +: CW]);
  endfunction
  function automatic int eff_of(int i);
    int e = int'(SLOT[i*CW +: CW]);
    if (act_of(i) > e) e = act_of(i);
    if (e < 1) e = 1;
    return e;
  endfunction

  // reference model
  bit m_run = 0, m_done = 0;
  int m_idx = 0, m_el = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin m_run = 0; m_done = 0; m_idx = 0; m_el = 0; end
    else if (!m_run) begin
      if (start) begin m_run = 1; m_done = 0; m_idx = 0; m_el = 0; end
    end else begin
      m_el++;
      if (m_el >= eff_of(m_idx)) begin
        m_el = 0;
        if (m_idx == U-1) begin m_run = 0; m_done = 1; m_idx = 0; end
        else m_idx++;
      end
    end
  end

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // per-run tallies observed at the ports
  int hi_cnt[U], slot_cnt[U];
  bit compare_on = 0;
  always @(negedge clk) begin
    logic [BW-1:0] e;
    if (compare_on) begin
      e = '0;
      if (m_run && m_el < act_of(m_idx)) e[m_idx] = 1'b1;
      chk("R3 fault_en", 64'(fault_en), 64'(e));
      chk("R6 fault_idx", 64'(fault_idx), 64'(m_idx));
      chk("R4 busy", 64'(busy), 64'(m_run));
      chk("R7 done", 64'(done), 64'(m_done));
      if (busy && fault_idx < U) begin
        slot_cnt[fault_idx]++;
        for (int i = 0; i < U; i++) if (fault_en[i]) hi_cnt[i]++;
      end
    end
  end

  task automatic clear_tally();
    for (int i = 0; i < U; i++) begin hi_cnt[i] = 0; slot_cnt[i] = 0; end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
  endtask

  task automatic check_tally();
    for (int i = 0; i < U; i++) begin
      chk($sformatf("R3 high cycles fault %0d", i), 64'(hi_cnt[i]), 64'(act_of(i)));
      chk($sformatf("R4 slot cycles fault %0d", i), 64'(slot_cnt[i]), 64'(eff_of(i)));
    end
    // R5: fault 2 slot count 3 stretched to active 5; fault 1 zero active
    chk("R5 stretched slot fault 2", 64'(slot_cnt[2]), 64'd5);
    chk("R5 zero-active fault 1 high", 64'(hi_cnt[1]), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    compare_on = 1;
    // R1
    chk("R1 fault_en", 64'(fault_en), 64'd0);
    chk("R1 idx", 64'(fault_idx), 64'd0);
    chk("R1 busy/done", 64'({busy, done}), 64'd0);

    // run 1: plain run
    clear_tally();
    @(negedge clk); start = 1; @(negedge clk); start = 0;
    chk("R2 first line", 64'(fault_en), 64'd1);
    chk("R2 busy", 64'(busy), 64'd1);
    wait_done();
    check_tally();
    repeat (4) @(negedge clk);
    chk("R7 quiet after done", 64'(fault_en), 64'd0);
    chk("R7 done held", 64'(done), 64'd1);

    // run 2: restart after done (R9) with start pulses mid-run (R8)
    clear_tally();
    pulse_start();
    chk("R9 done cleared", 64'(done), 64'd0);
    repeat (3) @(negedge clk);
    start = 1; @(negedge clk); start = 0;   // R8 during fault 0/1
    repeat (4) @(negedge clk);
    start = 1; repeat (2) @(negedge clk); start = 0; // R8 again
    wait_done();
    check_tally();

    // run 3: reset mid slot (R10)
    pulse_start();
    repeat (8) @(negedge clk);
    rst = 1; @(negedge clk); rst = 0;
    chk("R10 en after reset", 64'(fault_en), 64'd0);
    chk("R10 idx after reset", 64'(fault_idx), 64'd0);
    chk("R10 busy/done after reset", 64'({busy, done}), 64'd0);
    repeat (3) @(negedge clk);
    chk("R10 stays idle", 64'(busy), 64'd0);

    // run 4: fresh after reset
    clear_tally();
    pulse_start();
    wait_done();
    check_tally();
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule